// File: doc/BRIEF.md
# XGMII Transmit Frame Encoder

This block turns a stream of Ethernet frames, each running from the destination address through the frame check sequence, into the 64-bit, eight-lane transmit bus that a 10 Gb/s PHY expects. The frames arrive on a 64-bit byte stream with valid, ready, per-byte keep and last. The bus is driven on every clock. Between frames it carries idle codes. Each frame is wrapped in a start code, the preamble, the start-of-frame delimiter and a terminate code. The encoder computes no frame check sequence and does no gap-deficit accounting.

Input ready is pulled low while the encoder inserts words that carry no input bytes: the preamble word, a word that holds only a terminate code, and the mandatory idle word after each frame. Each accepted input beat therefore becomes exactly one payload word on the bus, one cycle later.

A controller with five named states drives the block:
- `ST_IDLE`: sends idles and leaves for `ST_PRE` when a beat is offered.
- `ST_PRE`: emits the preamble word and always moves to `ST_DATA`.
- `ST_DATA`: passes beats through. An ordinary beat stays in `ST_DATA`. A partial last beat goes to `ST_GAP`. A full last beat goes to `ST_TERM`.
- `ST_TERM`: emits a word whose only content is a terminate code, then moves to `ST_GAP`.
- `ST_GAP`: emits one idle word. It goes to `ST_PRE` if another frame is waiting, otherwise to `ST_IDLE`.

Top module: `xg_tx_enc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every lane carries idle (0x07 with its control bit set) and `s_ready` is low.
- R2: When no frame is in progress, each output word is 0x0707070707070707 with `xg_txc` equal to 8'hFF. Lane i occupies data bits [8i+7:8i], and control bit i flags it as a control code (1) or a payload byte (0).
- R3: A frame opens with a word in which lane 0 is 0xFB with control set, lanes 1 to 6 are 0x55 and lane 7 is 0xD5, with control clear on lanes 1 to 7. `s_ready` is low in the cycle before that word appears.
- R4: An accepted beat that is not the last beat, or that is a last beat with all eight keep bits set, appears on the bus in the next cycle unchanged, with `xg_txc` equal to 0. Consecutive beats leave no gap on the bus.
- R5: On a last beat whose keep holds k ones from lane 0 (1 ≤ k ≤ 7), lanes 0 to k-1 carry the data with control clear, lane k carries 0xFD with control set, and lanes above k carry 0x07 with control set.
- R6: After a last beat with all eight keep bits set, the next word has 0xFD in lane 0 and 0x07 in lanes 1 to 7, all with control set, and `s_ready` is low while that word is on the bus.
- R7: The word after any word that holds a terminate code is a full idle word. If the next frame is already offered, its start word follows that single idle word at once.
- R8: If `s_valid` is low while `s_ready` is high in the middle of a frame, the next word is 0xFE in every lane with control set, and the frame continues with the next accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 64 | Frame bytes, lane 0 in bits [7:0] |
| s_keep | input | 8 | Byte-valid flags; all ones except on the last beat |
| s_last | input | 1 | Marks the final beat of a frame |
| s_valid | input | 1 | A beat is offered |
| s_ready | output | 1 | Beat is taken at this clock edge |
| xg_txd | output | 64 | Transmit bus data, one byte per lane |
| xg_txc | output | 8 | Per-lane control flags |

## Verification
All bus words come from a register, so a beat accepted at one rising edge shows on `xg_txd`/`xg_txc` after the next rising edge. The preamble word appears two edges after a beat is first offered in `ST_IDLE`. A terminate-only word follows one edge after the full last payload word. The mandatory idle word follows the word that carries the terminate. The bench drives inputs and samples outputs at falling edges. Its driver pushes each expected word into a queue in that same order. Outside a frame, the monitor lets idle words pass. From the start word to the closing idle word, it pops one item on every cycle. Any dropped, extra or late word therefore shows up as a mismatch.

// File: rtl/xg_tx_pkg.sv
package xg_tx_pkg;

    localparam logic [7:0] CODE_IDLE  = 8'h07;
    localparam logic [7:0] CODE_START = 8'hFB;
    localparam logic [7:0] CODE_TERM  = 8'hFD;
    localparam logic [7:0] CODE_ERR   = 8'hFE;
    localparam logic [7:0] BYTE_PRE   = 8'h55;
    localparam logic [7:0] BYTE_SFD   = 8'hD5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_TERM,
        ST_GAP
    } enc_state_t;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_PRE,
        WK_DATA,
        WK_TERM0,
        WK_ERR
    } word_kind_t;

endpackage

// File: rtl/xg_tx_fsm.sv
module xg_tx_fsm
    import xg_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       keep_full,
    output logic       in_ready,
    output word_kind_t kind
);

    enc_state_t cur, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_IDLE: if (in_valid) nxt = ST_PRE;
            ST_PRE:  nxt = ST_DATA;
            ST_DATA: begin
                if (in_valid && in_last) nxt = keep_full ? ST_TERM : ST_GAP;
            end
            ST_TERM: nxt = ST_GAP;
            ST_GAP:  nxt = in_valid ? ST_PRE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        kind     = WK_IDLE;
        unique case (cur)
            ST_IDLE: kind = WK_IDLE;
            ST_PRE:  kind = WK_PRE;
            ST_DATA: begin
                in_ready = 1'b1;
                kind     = in_valid ? WK_DATA : WK_ERR;
            end
            ST_TERM: kind = WK_TERM0;
            ST_GAP:  kind = WK_IDLE;
            default: kind = WK_IDLE;
        endcase
    end

endmodule

// File: rtl/xg_tx_word.sv
module xg_tx_word
    import xg_tx_pkg::*;
#(
    parameter int LANES = 8,
    localparam int DW   = LANES * 8
) (
    input  word_kind_t       kind,
    input  logic [DW-1:0]    data,
    input  logic [LANES-1:0] keep,
    output logic [DW-1:0]    word_d,
    output logic [LANES-1:0] word_c
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic prev_kept;
        if (i == 0) begin : g_first
            assign prev_kept = 1'b1;
        end else begin : g_rest
            assign prev_kept = keep[i-1];
        end

        always_comb begin
            word_d[8*i +: 8] = CODE_IDLE;
            word_c[i]        = 1'b1;
            unique case (kind)
                WK_IDLE: begin
                    word_d[8*i +: 8] = CODE_IDLE;
                    word_c[i]        = 1'b1;
                end
                WK_ERR: begin
                    word_d[8*i +: 8] = CODE_ERR;
                    word_c[i]        = 1'b1;
                end
                WK_TERM0: begin
                    word_d[8*i +: 8] = (i == 0) ? CODE_TERM : CODE_IDLE;
                    word_c[i]        = 1'b1;
                end
                WK_PRE: begin
                    if (i == 0) begin
                        word_d[8*i +: 8] = CODE_START;
                        word_c[i]        = 1'b1;
                    end else begin
                        word_d[8*i +: 8] = (i == LANES-1) ? BYTE_SFD : BYTE_PRE;
                        word_c[i]        = 1'b0;
                    end
                end
                WK_DATA: begin
                    if (keep[i]) begin
                        word_d[8*i +: 8] = data[8*i +: 8];
                        word_c[i]        = 1'b0;
                    end else begin
                        word_d[8*i +: 8] = prev_kept ? CODE_TERM : CODE_IDLE;
                        word_c[i]        = 1'b1;
                    end
                end
                default: begin
                    word_d[8*i +: 8] = CODE_IDLE;
                    word_c[i]        = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/xg_tx_enc.sv
module xg_tx_enc
    import xg_tx_pkg::*;
#(
    parameter int LANES = 8,
    localparam int DW   = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    s_data,
    input  logic [LANES-1:0] s_keep,
    input  logic             s_last,
    input  logic             s_valid,
    output logic             s_ready,
    output logic [DW-1:0]    xg_txd,
    output logic [LANES-1:0] xg_txc
);

    word_kind_t       kind;
    logic [LANES-1:0] keep_eff;
    logic [DW-1:0]    nxt_d;
    logic [LANES-1:0] nxt_c;

    assign keep_eff = s_last ? s_keep : '1;

    xg_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_valid),
        .in_last   (s_last),
        .keep_full (&s_keep),
        .in_ready  (s_ready),
        .kind      (kind)
    );

    xg_tx_word #(.LANES(LANES)) u_word (
        .kind   (kind),
        .data   (s_data),
        .keep   (keep_eff),
        .word_d (nxt_d),
        .word_c (nxt_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xg_txd <= {LANES{CODE_IDLE}};
            xg_txc <= '1;
        end else begin
            xg_txd <= nxt_d;
            xg_txc <= nxt_c;
        end
    end

endmodule

// File: rtl/xg_tx_enc_chk.sv
module xg_tx_enc_chk
    import xg_tx_pkg::*;
#(
    parameter int LANES = 8,
    localparam int DW   = LANES * 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DW-1:0]    s_data,
    input logic [LANES-1:0] s_keep,
    input logic             s_last,
    input logic             s_valid,
    input logic             s_ready,
    input logic [DW-1:0]    xg_txd,
    input logic [LANES-1:0] xg_txc
);

    logic          has_term;
    logic [DW-1:0] pre_word;

    always_comb begin
        has_term = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (xg_txc[i] && xg_txd[8*i +: 8] == CODE_TERM) has_term = 1'b1;
        end
        pre_word = {BYTE_SFD, {(LANES-2){BYTE_PRE}}, CODE_START};
    end

    // R1: idle bus while held in reset
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (xg_txc == '1 && xg_txd == {LANES{CODE_IDLE}} && !s_ready);
        end
    end

    p_start_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_ready) |-> (xg_txd == pre_word && xg_txc == {{(LANES-1){1'b0}}, 1'b1}));

    p_payload_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_last) |=> (xg_txc == '0 && xg_txd == $past(s_data)));

    p_full_last_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last && (&s_keep)) |=> !s_ready);

    p_idle_after_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
        has_term |=> (xg_txc == '1 && xg_txd == {LANES{CODE_IDLE}}));

    p_underrun_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> (xg_txc == '1 && xg_txd == {LANES{CODE_ERR}}));

endmodule

bind xg_tx_enc xg_tx_enc_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/xg_tx_enc_tb.sv
module xg_tx_enc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_data = '0;
    logic [7:0]  s_keep = '0;
    logic        s_last = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [63:0] xg_txd;
    logic [7:0]  xg_txc;

    always #10 clk = ~clk;   // 50 MHz

    xg_tx_enc u_dut (.*);

    localparam logic [71:0] IDLE_W = {8'hFF, 64'h0707070707070707};
    localparam logic [71:0] PRE_W  = {8'h01, 64'hD5555555555555FB};
    localparam logic [71:0] ERR_W  = {8'hFF, 64'hFEFEFEFEFEFEFEFE};
    localparam logic [71:0] TRM_W  = {8'hFF, 64'h07070707070707FD};

    int checks = 0;
    int failures = 0;
    bit mon_en = 0;
    bit in_frame = 0;
    bit prev_ready = 0;
    int idle_run = 0;
    int last_gap = -1;

    logic [72:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [71:0] w, input bit last_item, input string tag);
        exp_q.push_back({last_item, w});
        tag_q.push_back(tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            logic [71:0] obs;
            logic [72:0] item;
            string t;
            obs = {xg_txc, xg_txd};
            if (!in_frame && obs == IDLE_W) begin
                idle_run++;
            end else if (exp_q.size() == 0) begin
                chk(0, "R2", obs, IDLE_W);
            end else begin
                item = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(obs == item[71:0], t, obs, item[71:0]);
                if (t == "R3") begin
                    chk(prev_ready == 1'b0, "R3", {71'd0, prev_ready}, 72'd0);
                    in_frame = 1;
                    last_gap = idle_run;
                    idle_run = 0;
                end
                if (t == "R6") chk(s_ready == 1'b0, "R6", {71'd0, s_ready}, 72'd0);
                if (item[72]) in_frame = 0;
            end
            prev_ready = s_ready;
        end
    end

    task automatic send_frame(input int nbeats, input logic [7:0] lastkeep,
                              input logic [7:0] seed, input int bubble_at);
        push(PRE_W, 0, "R3");
        for (int b = 0; b < nbeats; b++) begin
            logic [63:0] d;
            logic [7:0]  k;
            logic [71:0] w;
            int n;
            if (b == bubble_at) begin
                s_valid = 1'b0;
                while (!s_ready) @(negedge clk);
                push(ERR_W, 0, "R8");
                @(negedge clk);
            end
            d = {seed, 8'(b), 16'hA5C3, 32'(b) * 32'h01030507 ^ {4{seed}}};
            k = (b == nbeats - 1) ? lastkeep : 8'hFF;
            s_data = d; s_keep = k; s_last = (b == nbeats - 1); s_valid = 1'b1;
            while (!s_ready) @(negedge clk);
            if (b != nbeats - 1 || k == 8'hFF) begin
                push({8'h00, d}, 0, "R4");
            end else begin
                n = $countones(k);
                for (int j = 0; j < 8; j++) begin
                    if (j < n)       begin w[64+j] = 1'b0; w[8*j +: 8] = d[8*j +: 8]; end
                    else if (j == n) begin w[64+j] = 1'b1; w[8*j +: 8] = 8'hFD; end
                    else             begin w[64+j] = 1'b1; w[8*j +: 8] = 8'h07; end
                end
                push(w, 0, "R5");
            end
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
        if (lastkeep == 8'hFF) push(TRM_W, 0, "R6");
        push(IDLE_W, 1, "R7");
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({xg_txc, xg_txd} == IDLE_W, "R1", {xg_txc, xg_txd}, IDLE_W);
        chk(s_ready == 1'b0, "R1", {71'd0, s_ready}, 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({xg_txc, xg_txd} == IDLE_W && !s_ready, "R1", {xg_txc, xg_txd}, IDLE_W);
        mon_en = 1;
        settle(2);
        chk({xg_txc, xg_txd} == IDLE_W, "R2", {xg_txc, xg_txd}, IDLE_W);

        send_frame(3, 8'h0F, 8'h11, -1);  settle(4);   // R4 R5
        send_frame(2, 8'hFF, 8'h22, -1);  settle(4);   // R6
        send_frame(1, 8'h01, 8'h33, -1);  settle(4);   // R5 k=1
        send_frame(4, 8'h7F, 8'h44, -1);  settle(4);   // R5 k=7
        chk(last_gap > 0, "R2", 72'(last_gap), 72'd1);

        send_frame(2, 8'h07, 8'h55, -1);               // R7 back to back
        send_frame(2, 8'h3F, 8'h66, -1);
        settle(3);
        chk(last_gap == 0, "R7", 72'(last_gap), 72'd0);
        send_frame(1, 8'hFF, 8'h77, -1);               // R7 after full last
        send_frame(1, 8'h03, 8'h88, -1);
        settle(3);
        chk(last_gap == 0, "R7", 72'(last_gap), 72'd0);

        send_frame(3, 8'h1F, 8'h99, 1);   settle(5);   // R8 underrun
        chk(exp_q.size() == 0, "R4", 72'(exp_q.size()), 72'd0);
        chk({xg_txc, xg_txd} == IDLE_W, "R2", {xg_txc, xg_txd}, IDLE_W);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule